// File: doc/BRIEF.md
# Successive Approximation Sequencing Register

This block holds and steps the trial code of a successive approximation analog-to-digital converter. A synchronous active-low start loads the register with the mid-scale trial pattern: the most significant bit LOW and every other bit HIGH. The register outputs are active low, so a LOW bit adds its weight to the external digital-to-analog converter.

On each later rising clock edge a single LOW marker moves one place toward the least significant bit. The comparator decision on the serial input is written into the place the marker has just left. The first decision therefore lands in the top bit, the second in the next bit, and so on.

When the decision for the lowest bit is stored, the active-low done output falls and the register freezes until the next start. The serial input is also registered every clock onto its own output, and an inverted copy of the top bit is provided. The same block works as a plain serial-to-parallel converter, with the first bit at the top.

Top module: `sar_seq_top`

## Requirements
- R1: On every rising edge where startN is LOW, q becomes 0x7F (bit 7 LOW, bits 6..0 HIGH) and doneN becomes HIGH. This holds for as long as startN stays LOW.
- R2: startN acts only at a rising clock edge. A LOW pulse on startN that begins and ends between two rising edges leaves q and doneN unchanged.
- R3: On the first rising edge after startN returns HIGH, q[7] takes the value of serIn and q[6] is forced LOW.
- R4: On each of the next seven rising edges the LOW marker moves down one bit, to q[5] and onward to q[0]. The serIn value is stored in the bit the marker has just left.
- R5: A bit that has received a serIn value keeps it until the next start.
- R6: doneN falls on the same edge that stores serIn into q[0]. After that, q and doneN hold their values while startN stays HIGH, whatever serIn does.
- R7: qSync equals the serIn value sampled at the previous rising edge, on every edge including the frozen state.
- R8: qMsbN always equals the inverse of q[7].
- R9: A comparator that drives serIn HIGH when the target is below the code ~q makes ~q equal the 8-bit target once doneN is LOW.
- R10: A start applied in the middle of a conversion reloads 0x7F and restarts the sequence from q[7].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| startN | input | 1 | Synchronous start, active low |
| serIn | input | 1 | Serial decision bit from the comparator |
| q | output | 8 | Parallel register, active-low trial code |
| qMsbN | output | 1 | Inverse of q[7] |
| qSync | output | 1 | serIn registered on every edge |
| doneN | output | 1 | Conversion complete, active low |

## Verification
A marker counter that is off by one shows up at q within a single edge: a LOW appears in the wrong bit, or a decided bit gets overwritten, and the per-clock model comparison catches either. A lock that fails to hold, or a done flag that falls early or late, shows at doneN or q on the very edge involved. After a start, a wrong internal state cannot stay hidden for more than one clock. The comparator-driven runs also confirm that the eight stored decisions reassemble each random target exactly.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef struct packed {
    logic init;    // load mid-scale trial pattern
    logic step;    // store decision, advance marker
    logic finish;  // last decision, drop doneN
  } sarCtl_t;
endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int W = 8,
  localparam int IDX_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             startN,
  output sarCtl_t          ctl,
  output logic [IDX_W-1:0] pos
);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(W - 1);

  logic active;

  always_ff @(posedge clk) begin
    if (!startN) begin
      active <= 1'b1;
      pos    <= TOP;
    end else if (active) begin
      if (pos == '0) active <= 1'b0;
      else           pos    <= pos - 1'b1;
    end
  end

  always_comb begin
    ctl.init   = !startN;
    ctl.step   = startN && active;
    ctl.finish = startN && active && (pos == '0);
  end

  AST_INIT_POS: assert property (@(posedge clk)
    !startN |=> (active && pos == TOP)); // R1
  AST_DESCEND: assert property (@(posedge clk)
    (startN && active && pos != '0) |=> (active && pos == $past(pos) - 1'b1)); // R4
endmodule

// File: rtl/sar_seq_dp.sv
module sar_seq_dp
  import sar_seq_pkg::*;
#(
  parameter int W = 8,
  localparam int IDX_W = $clog2(W)
) (
  input  logic             clk,
  input  sarCtl_t          ctl,
  input  logic [IDX_W-1:0] pos,
  input  logic             serIn,
  output logic [W-1:0]     q,
  output logic             qSync,
  output logic             doneN
);
  localparam logic [W-1:0] INIT = {1'b0, {(W-1){1'b1}}};

  for (genvar i = 0; i < W; i++) begin : gBit
    if (i < W - 1) begin : gMid
      always_ff @(posedge clk) begin
        if (ctl.init)                                 q[i] <= INIT[i];
        else if (ctl.step && pos == IDX_W'(i))        q[i] <= serIn;
        else if (ctl.step && pos == IDX_W'(i + 1))    q[i] <= 1'b0;
      end
    end else begin : gTop
      always_ff @(posedge clk) begin
        if (ctl.init)                                 q[i] <= INIT[i];
        else if (ctl.step && pos == IDX_W'(i))        q[i] <= serIn;
      end
    end
  end

  always_ff @(posedge clk) begin
    qSync <= serIn;
    if (ctl.init)        doneN <= 1'b1;
    else if (ctl.finish) doneN <= 1'b0;
  end

  AST_INIT_PATTERN: assert property (@(posedge clk)
    ctl.init |=> (q == INIT && doneN)); // R1
  AST_LOCK_HOLD: assert property (@(posedge clk)
    (!ctl.init && !doneN) |=> ($stable(q) && !doneN)); // R6
  AST_DONE_CAUSE: assert property (@(posedge clk)
    $fell(doneN) |-> $past(ctl.step && pos == '0)); // R6
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
  import sar_seq_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         startN,
  input  logic         serIn,
  output logic [W-1:0] q,
  output logic         qMsbN,
  output logic         qSync,
  output logic         doneN
);
  localparam int IDX_W = $clog2(W);

  sarCtl_t          ctl;
  logic [IDX_W-1:0] pos;

  sar_seq_ctrl #(.W(W)) uCtrl (
    .clk(clk), .startN(startN), .ctl(ctl), .pos(pos)
  );

  sar_seq_dp #(.W(W)) uDp (
    .clk(clk), .ctl(ctl), .pos(pos), .serIn(serIn),
    .q(q), .qSync(qSync), .doneN(doneN)
  );

  assign qMsbN = ~q[W-1];
endmodule

// File: tb/tb_sar_seq_top.sv
module tb_sar_seq_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic startN = 1'b1;
  logic serIn = 1'b0;
  logic [W-1:0] q;
  logic qMsbN, qSync, doneN;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  logic [W-1:0] refQ;
  int refPos = -1;
  logic refDone = 1'b1;
  logic refSync = 1'b0;
  bit modelValid = 0;

  always #5 clk = ~clk;

  sar_seq_top #(.W(W)) dut (
    .clk(clk), .startN(startN), .serIn(serIn),
    .q(q), .qMsbN(qMsbN), .qSync(qSync), .doneN(doneN)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic modelEdge(input logic st, input logic si);
    refSync = si;
    if (!st) begin
      refQ = {1'b0, {(W-1){1'b1}}};
      refPos = W - 1;
      refDone = 1'b1;
    end else if (refPos >= 0) begin
      refQ[refPos] = si;
      if (refPos > 0) refQ[refPos-1] = 1'b0;
      else refDone = 1'b0;
      refPos--;
    end
  endtask

  task automatic compareAll();
    if (!modelValid) return;
    check(q == refQ, "R4/R5 q", int'(q), int'(refQ));
    check(doneN == refDone, "R6 doneN", int'(doneN), int'(refDone));
    check(qSync == refSync, "R7 qSync", int'(qSync), int'(refSync));
    check(qMsbN == ~q[W-1], "R8 qMsbN", int'(qMsbN), int'(~q[W-1]));
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic tick(input logic st, input logic si);
    startN = st;
    serIn = si;
    @(posedge clk);
    modelEdge(st, si);
    if (!st) modelValid = 1;
    @(negedge clk);
    compareAll();
  endtask

  task automatic convert(input logic [W-1:0] tgt, input int abortAt);
    logic [W-1:0] code;
    tick(1'b0, 1'b0);
    check(q == 8'h7F && doneN, "R1 init", int'(q), 8'h7F);
    for (int s = 0; s < W; s++) begin
      if (s == abortAt) begin
        tick(1'b0, 1'b1);
        check(q == 8'h7F && doneN, "R10 restart", int'(q), 8'h7F);
        s = -1;
        abortAt = -1;
        continue;
      end
      code = ~q;
      tick(1'b1, (tgt < code));
      if (s == 0)
        check(q[7] == (tgt < 8'h80) && q[6] == 1'b0, "R3 first step",
              int'(q[7:6]), int'({(tgt < 8'h80), 1'b0}));
    end
    check(!doneN, "R6 done after 8 steps", int'(doneN), 0);
    check(~q == tgt, "R9 final code", int'(~q), int'(tgt));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] held;
    @(negedge clk);
    tick(1'b1, 1'b0);
    tick(1'b1, 1'b1);
    // R1: start held LOW across several edges
    for (int k = 0; k < 3; k++) begin
      tick(1'b0, k[0]);
      check(q == 8'h7F && doneN, "R1 start held", int'(q), 8'h7F);
    end
    convert(8'hA5, -1);
    // R6: frozen state ignores serIn
    held = q;
    for (int k = 0; k < 4; k++) begin
      tick(1'b1, k[0]);
      check(q == held && !doneN, "R6 locked", int'(q), int'(held));
    end
    // R2: start pulse between edges has no effect
    startN = 1'b0;
    #2 startN = 1'b1;
    serIn = 1'b1;
    @(posedge clk);
    modelEdge(1'b1, 1'b1);
    @(negedge clk);
    compareAll();
    check(q == held && !doneN, "R2 glitch ignored", int'(q), int'(held));
    // corner targets and random targets
    convert(8'h00, -1);
    convert(8'hFF, -1);
    convert(8'h80, -1);
    convert(8'h7F, 3);
    for (int n = 0; n < 6; n++) convert(W'($urandom), -1);
    // plain serial-to-parallel use: first bit lands in q[7]
    tick(1'b0, 1'b0);
    for (int s = 0; s < W; s++) tick(1'b1, s[0]);
    check(q == 8'h55, "R4 serial to parallel", int'(q), 8'h55);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule